// File: doc/BRIEF.md
# Two-Subphase Request Parity Unit

This block produces and verifies the pair of parity wires that travel with a request on a shared processor bus. Every request spans two consecutive bus cycles, called sub-phases. The first carries the physical address and the second carries transaction-type information. Both cycles use the same 33 address/type lines and 5 request lines. The two parity wires are split across groups of these lines, and the split is swapped between the two sub-phases. Parity is defined on wire levels, not on logical values: a parity wire is high when an even number of the lines it covers are low.

The initiator half watches its own active-low strobe. In the strobe cycle it drives parity with the first-sub-phase grouping, and in the cycle after it uses the second-sub-phase grouping. At all other times it parks both parity wires high. The receiver half qualifies the bus with the incoming strobe. It checks each sub-phase against the grouping for that sub-phase and holds only the two mismatch bits of the first sub-phase. In the cycle after the second sub-phase it pulses one error output for each parity wire. Each of these outputs says which sub-phase failed. A strobe that arrives during a second sub-phase raises a protocol error, and that new request is dropped.

The address/type field is indexed 0 to 32, and field bit i is bus address line i+3. The high group is field bits 32:21. The low group is field bits 20:0 together with all 5 request lines.

Top module: `split_req_parity`

## Requirements
- R1: A parity wire is 1 when an even number of the wires it covers are 0, and 0 when that number is odd. When every covered wire is 1, both parity wires are 1.
- R2: In sub-phase 1, parity bit 0 covers the high group (field bits 32:21), and parity bit 1 covers the low group (field bits 20:0 plus the request lines).
- R3: In sub-phase 2 the coverage is swapped. Parity bit 1 covers the high group, and parity bit 0 covers the low group.
- R4: On the initiator side, the cycle with tx_strobe_n low uses the sub-phase 1 grouping on tx_par, combinationally from tx_addr and tx_req. The next cycle uses the sub-phase 2 grouping. In any cycle whose previous cycle had tx_strobe_n high and whose own tx_strobe_n is high, tx_par is 2'b11.
- R5: On the receiver side, a cycle with rx_strobe_n low while no request is open is sub-phase 1, and the next cycle is sub-phase 2. The error and protocol outputs are registered at the end of sub-phase 2. They are visible during the following cycle only, and they are 0 in the cycle after that.
- R6: rx_err0 reports parity bit 0 and rx_err1 reports parity bit 1. In each of them, bit [0] is 1 when sub-phase 1 mismatched and bit [1] is 1 when sub-phase 2 mismatched. Both bits may be set together.
- R7: If rx_strobe_n is low during sub-phase 2, rx_proto_err pulses with the same timing as the errors. The open request is still checked using that cycle's data. The new request is not opened, so no error is ever reported for it.
- R8: While no request is open and rx_strobe_n is high, the bus contents and rx_par produce no error.
- R9: Synchronous active-high rst closes any open request and clears every error output. A request that was open when rst was applied reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_strobe_n | input | 1 | Initiator strobe, low in sub-phase 1 |
| tx_addr | input | 33 | Initiator address/type wire levels |
| tx_req | input | 5 | Initiator request wire levels |
| tx_par | output | 2 | Parity wires driven with the request |
| rx_strobe_n | input | 1 | Observed strobe, active low |
| rx_addr | input | 33 | Observed address/type wire levels |
| rx_req | input | 5 | Observed request wire levels |
| rx_par | input | 2 | Observed parity wires |
| rx_err0 | output | 2 | Parity bit 0 failure, [0]=sub-phase 1, [1]=sub-phase 2 |
| rx_err1 | output | 2 | Parity bit 1 failure, [0]=sub-phase 1, [1]=sub-phase 2 |
| rx_proto_err | output | 1 | Strobe seen during sub-phase 2 |

## Verification
The bench drives single-line-low patterns into the high group in one sub-phase and into the low group in the other. A design that failed to swap the grouping, or that computed parity on inverted logic, would then produce the wrong tx_par. Corrupted parity is injected on one wire per sub-phase, on both wires in both sub-phases, and on crossed combinations. A design that merged or swapped the sub-phase bits, or that lost the first sub-phase result, would report the wrong error code. A strobe inside sub-phase 2 must raise the protocol flag and must not open a phantom request. Idle cycles with bad parity and a reset issued mid-request must both stay silent. A design that checked idle bus contents or kept stale state across reset would report errors there.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int ADDR_W_DEF = 33;
    localparam int REQ_W_DEF  = 5;
    localparam int HI_W_DEF   = 12;

    localparam logic [1:0] PAR_PARKED = 2'b11;

    typedef enum logic {
        SUB_ONE = 1'b0,
        SUB_TWO = 1'b1
    } subphase_e;

    typedef struct packed {
        logic hi;   // parity over the high address group
        logic lo;   // parity over the low address group plus request lines
    } grp_par_t;

    // Place group parities onto the two wires; the grouping swaps in sub-phase 2.
    function automatic logic [1:0] route_par(grp_par_t g, subphase_e s);
        if (s == SUB_ONE) return {g.lo, g.hi};
        return {g.hi, g.lo};
    endfunction

endpackage

// File: rtl/srp_parity_gen.sv
module srp_parity_gen
    import srp_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int REQ_W  = REQ_W_DEF,
    parameter int HI_W   = HI_W_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REQ_W-1:0]  req,
    input  subphase_e         sub,
    output logic [1:0]        par
);
    localparam int LO_W = ADDR_W - HI_W;

    grp_par_t grp;

    // Wire-level parity: high when the count of low wires is even.
    always_comb begin
        grp.hi = ~(^(~addr[ADDR_W-1:LO_W]));
        grp.lo = ~(^(~{addr[LO_W-1:0], req}));
        par    = route_par(grp, sub);
    end

    always_comb begin
        if (&{addr, req}) begin
            AST_ALL_HIGH_PAR: assert (par == PAR_PARKED); // R1
        end
    end

endmodule

// File: rtl/srp_tx_seq.sv
module srp_tx_seq
    import srp_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int REQ_W  = REQ_W_DEF,
    parameter int HI_W   = HI_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REQ_W-1:0]  req,
    output logic [1:0]        par
);
    logic       in_sub2;
    subphase_e  cur_sub;
    logic [1:0] gen_par;

    always_ff @(posedge clk) begin
        if (rst) in_sub2 <= 1'b0;
        else     in_sub2 <= !strobe_n && !in_sub2;
    end

    assign cur_sub = in_sub2 ? SUB_TWO : SUB_ONE;

    srp_parity_gen #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_gen (
        .addr (addr),
        .req  (req),
        .sub  (cur_sub),
        .par  (gen_par)
    );

    assign par = (!strobe_n || in_sub2) ? gen_par : PAR_PARKED;

    AST_TX_PARKED_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(strobe_n) && strobe_n) |-> (par == PAR_PARKED)); // R4

endmodule

// File: rtl/srp_rx_check.sv
module srp_rx_check
    import srp_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int REQ_W  = REQ_W_DEF,
    parameter int HI_W   = HI_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REQ_W-1:0]  req,
    input  logic [1:0]        par_in,
    output logic [1:0]        err0,
    output logic [1:0]        err1,
    output logic              proto_err
);
    logic       in_sub2;
    logic [1:0] s1_miss;
    logic [1:0] exp_par;
    logic [1:0] miss;
    subphase_e  cur_sub;

    assign cur_sub = in_sub2 ? SUB_TWO : SUB_ONE;

    srp_parity_gen #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_gen (
        .addr (addr),
        .req  (req),
        .sub  (cur_sub),
        .par  (exp_par)
    );

    assign miss = exp_par ^ par_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sub2   <= 1'b0;
            s1_miss   <= '0;
            err0      <= '0;
            err1      <= '0;
            proto_err <= 1'b0;
        end else begin
            err0      <= '0;
            err1      <= '0;
            proto_err <= 1'b0;
            if (!in_sub2) begin
                if (!strobe_n) begin
                    s1_miss <= miss;
                    in_sub2 <= 1'b1;
                end
            end else begin
                err0      <= {miss[0], s1_miss[0]};
                err1      <= {miss[1], s1_miss[1]};
                proto_err <= !strobe_n;
                in_sub2   <= 1'b0;
            end
        end
    end

    AST_REPORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ((|err0) || (|err1) || proto_err) |=> !((|err0) || (|err1) || proto_err)); // R5

    AST_ERR_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
        ((|err0) || (|err1)) |-> !$past(strobe_n, 2)); // R8

    AST_PROTO_IN_SUB2: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(!strobe_n) && $past(in_sub2))); // R7

endmodule

// File: rtl/split_req_parity.sv
module split_req_parity
    import srp_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int REQ_W  = REQ_W_DEF,
    parameter int HI_W   = HI_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_strobe_n,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [REQ_W-1:0]  tx_req,
    output logic [1:0]        tx_par,
    input  logic              rx_strobe_n,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [REQ_W-1:0]  rx_req,
    input  logic [1:0]        rx_par,
    output logic [1:0]        rx_err0,
    output logic [1:0]        rx_err1,
    output logic              rx_proto_err
);

    srp_tx_seq #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (tx_strobe_n),
        .addr     (tx_addr),
        .req      (tx_req),
        .par      (tx_par)
    );

    srp_rx_check #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .strobe_n  (rx_strobe_n),
        .addr      (rx_addr),
        .req       (rx_req),
        .par_in    (rx_par),
        .err0      (rx_err0),
        .err1      (rx_err1),
        .proto_err (rx_proto_err)
    );

endmodule

// File: tb/split_req_parity_tb.sv
module split_req_parity_tb;

    typedef struct packed {
        logic [32:0] a1;
        logic [4:0]  r1;
        logic [32:0] a2;
        logic [4:0]  r2;
        logic [1:0]  f1;
        logic [1:0]  f2;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{33'h1_FFFF_FFFF, 5'h1F, 33'h1_FFFF_FFFF, 5'h1F, 2'b00, 2'b00},
        '{33'h0_0000_0000, 5'h00, 33'h0_0000_0000, 5'h00, 2'b00, 2'b00},
        '{33'h0_FFFF_FFFF, 5'h1F, 33'h1_FFFF_FFFE, 5'h1F, 2'b00, 2'b00},
        '{33'h1_2345_6789, 5'h0A, 33'h0_DEAD_BEEF, 5'h15, 2'b01, 2'b00},
        '{33'h1_FFFF_FFFF, 5'h1E, 33'h1_FFE0_0000, 5'h1F, 2'b00, 2'b10},
        '{33'h0_5555_AAAA, 5'h03, 33'h1_0F0F_F0F0, 5'h1C, 2'b11, 2'b11},
        '{33'h1_8000_0001, 5'h11, 33'h0_7FFF_FFFE, 5'h0E, 2'b10, 2'b01}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_strobe_n = 1'b1;
    logic [32:0] tx_addr = '0;
    logic [4:0]  tx_req = '0;
    logic [1:0]  tx_par;
    logic        rx_strobe_n = 1'b1;
    logic [32:0] rx_addr = '0;
    logic [4:0]  rx_req = '0;
    logic [1:0]  rx_par = 2'b00;
    logic [1:0]  rx_err0;
    logic [1:0]  rx_err1;
    logic        rx_proto_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    split_req_parity u_dut (
        .clk(clk), .rst(rst),
        .tx_strobe_n(tx_strobe_n), .tx_addr(tx_addr), .tx_req(tx_req), .tx_par(tx_par),
        .rx_strobe_n(rx_strobe_n), .rx_addr(rx_addr), .rx_req(rx_req), .rx_par(rx_par),
        .rx_err0(rx_err0), .rx_err1(rx_err1), .rx_proto_err(rx_proto_err)
    );

    // Independent model: count low wires per group, then route by sub-phase.
    function automatic logic [1:0] model_par(logic [32:0] a, logic [4:0] r, bit sub2);
        int zh = 0;
        int zl = 0;
        logic ph, pl;
        for (int i = 21; i <= 32; i++) if (a[i] == 1'b0) zh++;
        for (int i = 0; i <= 20; i++) if (a[i] == 1'b0) zl++;
        for (int i = 0; i < 5; i++) if (r[i] == 1'b0) zl++;
        ph = (zh % 2 == 0);
        pl = (zl % 2 == 0);
        return sub2 ? {ph, pl} : {pl, ph};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_both(bit strobe_n, logic [32:0] a, logic [4:0] r, logic [1:0] p);
        tx_strobe_n = strobe_n; rx_strobe_n = strobe_n;
        tx_addr = a; rx_addr = a; tx_req = r; rx_req = r; rx_par = p;
    endtask

    task automatic run_req(vec_t v, bit proto_strobe);
        @(negedge clk);
        drive_both(1'b0, v.a1, v.r1, model_par(v.a1, v.r1, 1'b0) ^ v.f1);
        #1 check("R2 tx_par sub-phase 1", {6'd0, tx_par}, {6'd0, model_par(v.a1, v.r1, 1'b0)});
        @(negedge clk);
        drive_both(proto_strobe ? 1'b0 : 1'b1, v.a2, v.r2, model_par(v.a2, v.r2, 1'b1) ^ v.f2);
        #1 check("R3 tx_par sub-phase 2", {6'd0, tx_par}, {6'd0, model_par(v.a2, v.r2, 1'b1)});
        @(negedge clk);
        // idle garbage with wrong parity: must be ignored (R8)
        drive_both(1'b1, 33'h0_1234_5678, 5'h07, ~model_par(33'h0_1234_5678, 5'h07, 1'b0));
        #1;
        check("R6 rx_err0", {6'd0, rx_err0}, {6'd0, v.f2[0], v.f1[0]});
        check("R6 rx_err1", {6'd0, rx_err1}, {6'd0, v.f2[1], v.f1[1]});
        check("R7 rx_proto_err", {7'd0, rx_proto_err}, {7'd0, proto_strobe});
        check("R4 tx_par parked", {6'd0, tx_par}, 8'h03);
        @(negedge clk);
        #1 check("R5 report cleared", {3'd0, rx_err0, rx_err1, rx_proto_err}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset outputs", {3'd0, rx_err0, rx_err1, rx_proto_err}, 8'h00);
        check("R4 tx_par parked in reset", {6'd0, tx_par}, 8'h03);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) run_req(VEC[k], 1'b0);

        // R8: idle cycles with corrupt parity never report
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drive_both(1'b1, 33'h1_0000_0000 >> k, 5'h01, 2'b00 ^ model_par(33'h1_0000_0000 >> k, 5'h01, 1'b0) ^ 2'b11);
            #1 check("R8 idle ignored", {3'd0, rx_err0, rx_err1, rx_proto_err}, 8'h00);
        end

        // R7: strobe during sub-phase 2, open request still checked
        run_req(VEC[4], 1'b1);
        // R7: dropped request produced nothing one cycle later either
        @(negedge clk);
        #1 check("R7 dropped request silent", {3'd0, rx_err0, rx_err1, rx_proto_err}, 8'h00);

        // R9: reset in the middle of a request with bad parity
        @(negedge clk);
        drive_both(1'b0, VEC[5].a1, VEC[5].r1, ~model_par(VEC[5].a1, VEC[5].r1, 1'b0));
        @(negedge clk);
        rst = 1'b1;
        drive_both(1'b1, VEC[5].a2, VEC[5].r2, ~model_par(VEC[5].a2, VEC[5].r2, 1'b1));
        @(negedge clk);
        #1 check("R9 mid-request reset", {3'd0, rx_err0, rx_err1, rx_proto_err}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        #1 check("R9 no stale report", {3'd0, rx_err0, rx_err1, rx_proto_err}, 8'h00);
        check("R1 all-high parked", {6'd0, tx_par}, 8'h03);

        // clean request after reset
        run_req(VEC[6], 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule